// File: doc/BRIEF.md
# Dual-Port Bridge Control Register File

This block holds the 64-bit configuration and status registers of a host-bridge control unit. Two requesters reach the same storage: a scan-communication port and a memory-mapped port. Both present a byte address and 64-bit data on one shared request channel, and a select bit says which path the request uses. The two paths turn the byte address into a register index in different ways. The memory-mapped path skips the first ten register slots, so its window starts at the base-address register.

Most registers are plain storage. Several locations instead act on a shared register:
- Two alias indices AND or OR the write data into the fault register.
- Two other alias indices set or clear bits of the control register.
- The base-address register keeps only its address field and its enable bit, and only the scan path may change it.

The interrupt-routing registers are kept here as masked storage. Their meaning is decoded by a neighbouring block. The block drives the base-address enable bit out as a pin. It also pulses a strobe whenever the control register's memory-mapped-enable bit (bit 62) flips. Any access that is illegal or lands on an unimplemented location raises an error flag in the response.

Top module: `bridge_regfile`

## Requirements
- R1: On the scan path (req_is_mmio=0) the register index is req_addr>>3.
- R2: On the memory-mapped path (req_is_mmio=1) the register index is (req_addr>>3)+10. So memory-mapped byte address 0x00 reaches index 0x0A and 0x20 reaches index 0x0E.
- R3: Index 0x00 is the fault register and takes written data as is. A write to index 0x01 stores fault & data into it. A write to index 0x02 stores fault | data into it.
- R4: Index 0x0E is the control register and takes written data as is. A write to index 0x12 stores ctrl | data. A write to index 0x13 stores ctrl & ~data.
- R5: A scan-path write to index 0x0A stores data & 0x0003fffffff00001. The output bar_en always equals bit 0 of that register.
- R6: A memory-mapped write to index 0x0A leaves the base register unchanged and returns rsp_err=1.
- R7: A write to index 0x0B stores data & 0x0003ffff00000000.
- R8: Index 0x15 (interrupt status) reads back its stored value, which is zero. A write to it is dropped and returns rsp_err=1.
- R9: The following return rdata 0xFFFFFFFFFFFFFFFF (for a read) and rsp_err=1, and change nothing:
  - a read of any index outside {0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x10, 0x14, 0x15, 0x16..0x1B};
  - a write to any index outside those plus {0x01, 0x02, 0x12, 0x13};
  - any access whose req_addr[2:0] is not zero.
- R10: After reset every register reads zero, except index 0x0A, which reads (BAR_RESET & 0x0003fffffff00000) | 1. bar_en is then 1.
- R11: ctrl_mmio_chg is high for exactly the response cycle of a write that changes control bit 62. It is low otherwise.
- R12: req_ready is always 1. rsp_valid is high exactly in the cycle after a cycle with req_valid high. A write's response carries rdata 0.
- R13: Indices 0x06, 0x07, 0x0F and 0x14 store all 64 bits. The routing registers 0x10 and 0x16..0x1A store data & 0x00ffffffe0000000. Index 0x1B stores data & 0xffffe00f00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; every valid request is taken |
| req_is_mmio | input | 1 | 1 selects the memory-mapped path, 0 the scan path |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address on the selected path |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, all ones on a failed read, zero for writes |
| rsp_err | output | 1 | Illegal or unimplemented access |
| bar_en | output | 1 | Enable bit of the base-address register |
| ctrl_mmio_chg | output | 1 | One-cycle pulse when control bit 62 flips |

## Verification
The assertions take for granted that every request input is a known value whenever req_valid is high. Because req_ready is tied high, they also assume that a valid held for two cycles is meant as two requests. The response-timing and strobe properties rely on ctrl_q and the response registers starting from reset, so they are disabled while rst_n is low. The stimulus drives each request for exactly one cycle, between clock edges. It leaves an idle cycle after each request, so every response and every idle gap can be checked at the ports.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;

  localparam int unsigned DATA_W    = 64;
  localparam int unsigned NREG      = 28;
  localparam int unsigned MMIO_BIAS = 10;

  // Register indices whose position the behaviour depends on.
  localparam int unsigned IDX_FAULT = 0;
  localparam int unsigned IDX_BAR   = 10;
  localparam int unsigned IDX_CTRL  = 14;
  localparam int unsigned IDX_ISTAT = 21;
  localparam int unsigned CTRL_MMIO_BIT = 62;

  localparam logic [DATA_W-1:0] BAR_ADDR_MASK = 64'h0003_ffff_fff0_0000;
  localparam logic [DATA_W-1:0] BAR2_MASK     = 64'h0003_ffff_0000_0000;
  localparam logic [DATA_W-1:0] ROUTE_MASK    = 64'h00ff_ffff_e000_0000;
  localparam logic [DATA_W-1:0] SRCCMP_MASK   = 64'hffff_e00f_0000_0000;
  localparam logic [DATA_W-1:0] ALL_ONES      = '1;

  typedef enum logic [2:0] {
    K_NONE, K_PLAIN, K_BAR, K_RDONLY,
    K_FAULT_AND, K_FAULT_OR, K_CTRL_SET, K_CTRL_CLR
  } kind_e;

  // Role of each register index.
  function automatic kind_e f_kind(int unsigned idx);
    case (idx)
      0, 6, 7, 11, 14, 15, 16, 20,
      22, 23, 24, 25, 26, 27: return K_PLAIN;
      1:  return K_FAULT_AND;
      2:  return K_FAULT_OR;
      10: return K_BAR;
      18: return K_CTRL_SET;
      19: return K_CTRL_CLR;
      21: return K_RDONLY;
      default: return K_NONE;
    endcase
  endfunction

  // Bits kept by a direct write to an index.
  function automatic logic [DATA_W-1:0] f_wmask(int unsigned idx);
    case (idx)
      10: return BAR_ADDR_MASK | 64'h1;
      11: return BAR2_MASK;
      16, 22, 23, 24, 25, 26: return ROUTE_MASK;
      27: return SRCCMP_MASK;
      default: return ALL_ONES;
    endcase
  endfunction

  function automatic logic f_has_store(int unsigned idx);
    kind_e k;
    k = f_kind(idx);
    return (k == K_PLAIN) || (k == K_BAR) || (k == K_RDONLY);
  endfunction

  // Byte address to index, per path.
  function automatic int unsigned f_index(logic is_mmio, int unsigned word);
    return is_mmio ? word + MMIO_BIAS : word;
  endfunction

endpackage

// File: rtl/brf_addrmap.sv
`timescale 1ns/1ps
module brf_addrmap
  import brf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              is_mmio,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              misaligned
);
  localparam int unsigned WORD_W = ADDR_W - 3;

  logic [WORD_W-1:0] word;

  assign word       = addr[ADDR_W-1:3];
  assign idx        = IDX_W'(f_index(is_mmio, 32'(word)));
  assign misaligned = |addr[2:0];

endmodule

// File: rtl/brf_decode.sv
`timescale 1ns/1ps
module brf_decode
  import brf_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_is_mmio,
  input  logic [IDX_W-1:0]  idx,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] fault_q,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [NREG-1:0]   wr_vec,
  output logic [DATA_W-1:0] wr_val,
  output logic              acc_bad,
  output logic              rd_hit
);
  kind_e kind;

  assign kind = f_kind(32'(idx));

  always_comb begin
    wr_vec  = '0;
    wr_val  = wdata & f_wmask(32'(idx));
    acc_bad = 1'b0;
    rd_hit  = 1'b0;
    if (req_valid) begin
      if (misaligned || kind == K_NONE) begin
        acc_bad = 1'b1;
      end else if (req_write) begin
        case (kind)
          K_RDONLY: acc_bad = 1'b1;
          K_BAR: begin
            if (req_is_mmio) acc_bad = 1'b1;
            else             wr_vec[IDX_BAR] = 1'b1;
          end
          K_FAULT_AND: begin
            wr_vec[IDX_FAULT] = 1'b1;
            wr_val = fault_q & wdata;
          end
          K_FAULT_OR: begin
            wr_vec[IDX_FAULT] = 1'b1;
            wr_val = fault_q | wdata;
          end
          K_CTRL_SET: begin
            wr_vec[IDX_CTRL] = 1'b1;
            wr_val = ctrl_q | wdata;
          end
          K_CTRL_CLR: begin
            wr_vec[IDX_CTRL] = 1'b1;
            wr_val = ctrl_q & ~wdata;
          end
          default: wr_vec = NREG'(1) << idx;
        endcase
      end else begin
        if (kind == K_FAULT_AND || kind == K_FAULT_OR ||
            kind == K_CTRL_SET  || kind == K_CTRL_CLR)
          acc_bad = 1'b1;
        else
          rd_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/brf_store.sv
`timescale 1ns/1ps
module brf_store
  import brf_pkg::*;
#(
  parameter int unsigned       IDX_W     = 6,
  parameter logic [DATA_W-1:0] BAR_RESET = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_vec,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] fault_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] bar_q
);
  localparam logic [DATA_W-1:0] BAR_INIT = (BAR_RESET & BAR_ADDR_MASK) | 64'h1;

  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (f_has_store(g)) begin : g_reg
      localparam logic [DATA_W-1:0] INIT = (g == IDX_BAR) ? BAR_INIT : '0;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= INIT;
        else if (wr_vec[g]) q <= wr_val;
      end
      assign regs[g] = q;
    end else begin : g_none
      assign regs[g] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (32'(rd_idx) == i) rd_val = regs[i];
  end

  assign fault_q = regs[IDX_FAULT];
  assign ctrl_q  = regs[IDX_CTRL];
  assign bar_q   = regs[IDX_BAR];

  // R3 / R4: an alias write targets only its shared register.
  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R5: base register never holds bits outside its address field and enable.
  assert_bar_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_q & ~(BAR_ADDR_MASK | 64'h1)) == '0);

  // R8: the status register never takes a write.
  assert_istat_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vec[IDX_ISTAT]);

endmodule

// File: rtl/bridge_regfile.sv
`timescale 1ns/1ps
module bridge_regfile
  import brf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [63:0] BAR_RESET = 64'h0003_fffe_8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_mmio,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              bar_en,
  output logic              ctrl_mmio_chg
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              misaligned;
  logic [NREG-1:0]   wr_vec;
  logic [DATA_W-1:0] wr_val, rd_val, fault_q, ctrl_q, bar_q;
  logic              acc_bad, rd_hit;
  logic              ctrl_flip;
  logic              mmio_bar_write;

  brf_addrmap #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_map (
    .is_mmio(req_is_mmio), .addr(req_addr), .idx(idx), .misaligned(misaligned)
  );

  brf_decode #(.IDX_W(IDX_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_is_mmio(req_is_mmio),
    .idx(idx), .misaligned(misaligned), .wdata(req_wdata),
    .fault_q(fault_q), .ctrl_q(ctrl_q),
    .wr_vec(wr_vec), .wr_val(wr_val), .acc_bad(acc_bad), .rd_hit(rd_hit)
  );

  brf_store #(.IDX_W(IDX_W), .BAR_RESET(BAR_RESET)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .wr_val(wr_val),
    .rd_idx(idx), .rd_val(rd_val),
    .fault_q(fault_q), .ctrl_q(ctrl_q), .bar_q(bar_q)
  );

  assign req_ready      = 1'b1;
  assign bar_en         = bar_q[0];
  assign ctrl_flip      = wr_vec[IDX_CTRL] &&
                          (wr_val[CTRL_MMIO_BIT] != ctrl_q[CTRL_MMIO_BIT]);
  assign mmio_bar_write = req_valid && req_write && req_is_mmio && !misaligned &&
                          (32'(idx) == IDX_BAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      ctrl_mmio_chg <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_err       <= acc_bad;
      ctrl_mmio_chg <= ctrl_flip;
      if (req_valid && !req_write) rsp_rdata <= rd_hit ? rd_val : ALL_ONES;
      else                         rsp_rdata <= '0;
    end
  end

  // R12: one response exactly one cycle after each request.
  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R9: an error is only reported inside a response.
  assert_err_in_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R6: memory-mapped base writes leave the base register alone and flag.
  assert_mmio_bar_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_bar_write |=> ($stable(bar_q) && rsp_err));

  // R11: the strobe means control bit 62 really moved.
  assert_chg_means_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_mmio_chg |-> (ctrl_q[CTRL_MMIO_BIT] != $past(ctrl_q[CTRL_MMIO_BIT])));

endmodule

// File: tb/sim_bridge_regfile.sv
`timescale 1ns/1ps
module sim_bridge_regfile;

  localparam int unsigned ADDR_W   = 8;
  localparam logic [63:0] BAR_DEF  = 64'h0003_fffe_8000_0000;
  localparam logic [63:0] ONES     = 64'hffff_ffff_ffff_ffff;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_is_mmio = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              rsp_err;
  logic              bar_en;
  logic              ctrl_mmio_chg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] mdl [64];

  always #4 clk = ~clk;

  bridge_regfile #(.ADDR_W(ADDR_W), .BAR_RESET(BAR_DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_mmio(req_is_mmio), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .bar_en(bar_en), .ctrl_mmio_chg(ctrl_mmio_chg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit readable(int i);
    return i inside {0, 6, 7, 10, 11, 14, 15, 16, 20, 21, [22:27]};
  endfunction

  // Reference behaviour, written from the requirements.
  task automatic model(input bit mm, input bit wr, input int i, input logic [63:0] d,
                       input bit mis, output logic [63:0] er, output bit ee,
                       output bit ec);
    logic [63:0] old;
    er = '0; ee = 1'b0; ec = 1'b0;
    if (mis) begin
      ee = 1'b1;
      er = wr ? 64'h0 : ONES;
      return;
    end
    if (!wr) begin
      ee = !readable(i);
      er = readable(i) ? mdl[i] : ONES;
      return;
    end
    old = mdl[14];
    case (i)
      0: mdl[0] = d;
      1: mdl[0] = mdl[0] & d;
      2: mdl[0] = mdl[0] | d;
      6, 7, 15, 20: mdl[i] = d;
      10: if (mm) ee = 1'b1; else mdl[10] = d & 64'h0003_ffff_fff0_0001;
      11: mdl[11] = d & 64'h0003_ffff_0000_0000;
      14: mdl[14] = d;
      18: mdl[14] = old | d;
      19: mdl[14] = old & ~d;
      16, 22, 23, 24, 25, 26: mdl[i] = d & 64'h00ff_ffff_e000_0000;
      27: mdl[27] = d & 64'hffff_e00f_0000_0000;
      default: ee = 1'b1;
    endcase
    ec = (mdl[14][62] != old[62]);
  endtask

  task automatic access(input bit mm, input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [63:0] d, input string req);
    logic [63:0] er;
    bit ee, ec;
    int i;
    i = int'(a >> 3) + (mm ? 10 : 0);
    model(mm, wr, i, d, |a[2:0], er, ee, ec);
    @(negedge clk);
    check(!rsp_valid, "R12", "idle rsp_valid", 64'(rsp_valid), 64'h0);
    check(req_ready, "R12", "req_ready", 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_is_mmio = mm; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid, "R12", "rsp_valid", 64'(rsp_valid), 64'h1);
    check(rsp_rdata == er, req, $sformatf("rdata idx %0d", i), rsp_rdata, er);
    check(rsp_err == ee, req, $sformatf("err idx %0d", i), 64'(rsp_err), 64'(ee));
    check(ctrl_mmio_chg == ec, "R11", $sformatf("chg idx %0d", i),
          64'(ctrl_mmio_chg), 64'(ec));
    check(bar_en == mdl[10][0], "R5", "bar_en", 64'(bar_en), 64'(mdl[10][0]));
  endtask

  function automatic logic [63:0] pat(int i, logic [63:0] seed);
    return seed ^ {32'(i) * 32'h9E37_79B9, 32'(i) * 32'h7F4A_7C15};
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mdl[10] = (BAR_DEF & 64'h0003_ffff_fff0_0000) | 64'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports.
    check(bar_en, "R10", "reset bar_en", 64'(bar_en), 64'h1);
    check(!rsp_valid, "R10", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    for (int w = 0; w < 32; w++) access(1'b0, 1'b0, ADDR_W'(w * 8), '0, "R10");

    // R1: scan-path write then read sweep over every word.
    for (int w = 0; w < 32; w++) access(1'b0, 1'b1, ADDR_W'(w * 8), pat(w, 64'hC3A5_5A3C_F00F_0FF0), "R1");
    for (int w = 0; w < 32; w++) access(1'b0, 1'b0, ADDR_W'(w * 8), '0, "R1");

    // R2: memory-mapped sweep, includes the blocked base write (R6).
    for (int w = 0; w < 32; w++) access(1'b1, 1'b1, ADDR_W'(w * 8), pat(w, 64'h6B1D_E229_4C87_93F1), "R2");
    for (int w = 0; w < 32; w++) access(1'b1, 1'b0, ADDR_W'(w * 8), '0, "R2");
    access(1'b1, 1'b1, 8'h00, ONES, "R6");
    access(1'b0, 1'b0, 8'h50, '0, "R6");

    // R3: fault aliases.
    access(1'b0, 1'b1, 8'h00, 64'hFF00_FF00_1234_5678, "R3");
    access(1'b0, 1'b1, 8'h08, 64'h0F0F_0F0F_FFFF_0000, "R3");
    access(1'b0, 1'b0, 8'h00, '0, "R3");
    access(1'b0, 1'b1, 8'h10, 64'h8000_0000_0000_0001, "R3");
    access(1'b0, 1'b0, 8'h00, '0, "R3");

    // R4 / R11: control set and clear, strobe on bit 62 flips only.
    access(1'b0, 1'b1, 8'h70, '0, "R4");
    access(1'b0, 1'b1, 8'h90, 64'h4000_0000_0000_00F0, "R4");
    access(1'b0, 1'b1, 8'h90, 64'h4000_0000_0000_0F00, "R11");
    access(1'b1, 1'b0, 8'h20, '0, "R4");
    access(1'b0, 1'b1, 8'h98, 64'h4000_0000_0000_0010, "R11");
    access(1'b0, 1'b1, 8'h98, 64'h0000_0000_0000_0100, "R4");
    access(1'b0, 1'b0, 8'h70, '0, "R4");

    // R5: base enable follows bit 0.
    access(1'b0, 1'b1, 8'h50, ONES - 64'h1, "R5");
    access(1'b0, 1'b0, 8'h50, '0, "R5");
    access(1'b0, 1'b1, 8'h50, ONES, "R5");

    // R7, R8, R13: masked storage and read-only status.
    access(1'b0, 1'b1, 8'h58, ONES, "R7");
    access(1'b0, 1'b0, 8'h58, '0, "R7");
    access(1'b0, 1'b1, 8'hA8, ONES, "R8");
    access(1'b0, 1'b0, 8'hA8, '0, "R8");
    access(1'b0, 1'b1, 8'h80, ONES, "R13");
    access(1'b0, 1'b0, 8'h80, '0, "R13");
    access(1'b0, 1'b1, 8'hD8, ONES, "R13");
    access(1'b0, 1'b0, 8'hD8, '0, "R13");
    access(1'b0, 1'b1, 8'hA0, ONES, "R13");
    access(1'b0, 1'b0, 8'hA0, '0, "R13");

    // R9: misaligned and unimplemented accesses change nothing.
    for (int b = 1; b < 8; b++) access(1'b0, 1'b1, ADDR_W'(b), 64'hDEAD_BEEF_0000_0000, "R9");
    access(1'b0, 1'b0, 8'h00, '0, "R9");
    access(1'b1, 1'b1, 8'h23, ONES, "R9");
    access(1'b1, 1'b0, 8'h21, '0, "R9");
    access(1'b0, 1'b1, 8'hF8, ONES, "R9");
    access(1'b0, 1'b0, 8'hF8, '0, "R9");
    access(1'b0, 1'b0, 8'h70, '0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule